// File: doc/BRIEF.md
# Chainable Four-Bit Up/Down Counter

This block is a small binary counter that steps up or down by one on each rising clock edge while its active-low enable is asserted. Two asynchronous controls sit above the clocked count: a clear input that forces the count to zero at once, and a level-sensitive load input that makes the count track a data word for as long as it is held high. Clear wins over load, and load wins over counting.

The active-low terminal output goes low when the count sits at its extreme for the selected direction and the stage is enabled. It reaches full value when counting up and zero when counting down. Because this decode includes the enable, the terminal output of one stage can drive the enable of the next. A row of stages sharing one clock then behaves as a single wider synchronous counter. The stage width is a parameter and defaults to four bits.

Top module: `updown_cascade_counter`

## Requirements
- R1: While `clear` is high the count is zero, without waiting for a clock edge and regardless of load, enable and direction.
- R2: While `load` is high and `clear` is low, `count` equals `load_val` without any clock edge, independent of enable and direction.
- R3: With `clear` and `load` low, `enable_n` low and `count_up` high (1 = up), each rising clock edge adds one to the count.
- R4: With `clear` and `load` low, `enable_n` low and `count_up` low (0 = down), each rising clock edge subtracts one from the count.
- R5: With `enable_n` high and `clear` and `load` low, clock edges leave the count unchanged.
- R6: Counting up from full value gives zero, and counting down from zero gives full value.
- R7: `term_n` is low exactly when `enable_n` is low and either `count_up` is 1 with the count at full value or `count_up` is 0 with the count at zero. It follows changes in enable and direction with no clock edge.
- R8: When `load` falls, the count keeps the loaded word and later counting starts from it.
- R9: Two stages that share clock and direction, with the low stage's `term_n` driving the high stage's `enable_n`, count as one eight-bit counter {high,low} and wrap from 255 to 0 and from 0 to 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge active |
| clear | input | 1 | Asynchronous clear to zero, active high, highest priority |
| load | input | 1 | Asynchronous level-sensitive load, active high |
| count_up | input | 1 | Direction: 1 counts up, 0 counts down |
| enable_n | input | 1 | Count enable, active low |
| load_val | input | W | Parallel data taken while load is high |
| count | output | W | Current count |
| term_n | output | 1 | Terminal count, active low, gated by enable |

## Verification
The step properties assume that `clear` and `load` do not pulse between two clock edges in a stretch where a count step is being checked, and that inputs change away from the rising edge. The bench changes every input on the falling edge and raises or lowers the asynchronous controls only around whole-cycle windows. After `load` falls, the held value is the data present at the last rising edge or load rise. The bench therefore lets at least one clock edge pass after changing `load_val` before it drops `load`.

// File: rtl/udc_pkg.sv
// Package: shared direction type for the up/down counter stage.
// Assumes: a one-bit direction select where 1 means counting up.
package udc_pkg;
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;
endpackage

// File: rtl/udc_step.sv
// Module: computes the neighbouring count value in the chosen direction.
// Assumes: modular arithmetic on W bits supplies both wraparounds.
module udc_step #(
    parameter int W = 4
) (
    input  logic [W-1:0]  cur,
    input  udc_pkg::dir_e dir,
    output logic [W-1:0]  nxt
);
    localparam logic [W-1:0] ONE = W'(1);

    // Select increment or decrement of the current count.
    always_comb begin
        if (dir == udc_pkg::DIR_UP) nxt = cur + ONE;
        else                        nxt = cur - ONE;
    end
endmodule

// File: rtl/udc_state.sv
// Module: count register with asynchronous clear and load.
// Assumes: clear outranks load. Load data is taken at the load rise and
// again at every clock edge while load is high.
module udc_state #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step_en,
    input  logic [W-1:0] nxt,
    output logic [W-1:0] st
);
    // Hold the count; asynchronous clear, then load, then clocked step.
    always_ff @(posedge clk or posedge clear or posedge load) begin
        if (clear)        st <= '0;
        else if (load)    st <= load_val;
        else if (step_en) st <= nxt;
    end
endmodule

// File: rtl/udc_term.sv
// Module: decodes the active-low terminal indication of one stage.
// Assumes: the terminal value is all ones upward and all zeros downward.
module udc_term #(
    parameter int W = 4
) (
    input  logic [W-1:0]  cnt,
    input  udc_pkg::dir_e dir,
    input  logic          enable_n,
    output logic          term_n
);
    logic [W-1:0] hit_up;
    logic [W-1:0] hit_dn;

    // One match bit per count bit for each direction.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign hit_up[i] = cnt[i];
        assign hit_dn[i] = ~cnt[i];
    end

    // Combine direction match with the enable.
    always_comb begin
        logic at_end;
        at_end = (dir == udc_pkg::DIR_UP) ? (&hit_up) : (&hit_dn);
        term_n = ~(at_end & ~enable_n);
    end
endmodule

// File: rtl/updown_cascade_counter.sv
// Module: top of one chainable up/down counter stage.
// Assumes: controls obey clear > load > count. While load is high the output
// shows load_val directly. term_n may feed the next stage's enable_n.
module updown_cascade_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clear,
    input  logic         load,
    input  logic         count_up,
    input  logic         enable_n,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         term_n
);
    udc_pkg::dir_e dir;
    logic [W-1:0]  st;
    logic [W-1:0]  nxt;

    // Map the direction pin onto the shared type.
    always_comb dir = count_up ? udc_pkg::DIR_UP : udc_pkg::DIR_DOWN;

    udc_step #(.W(W)) i_step (
        .cur (st),
        .dir (dir),
        .nxt (nxt)
    );

    udc_state #(.W(W)) i_state (
        .clk      (clk),
        .clear    (clear),
        .load     (load),
        .load_val (load_val),
        .step_en  (~enable_n),
        .nxt      (nxt),
        .st       (st)
    );

    // Visible count: clear and load act transparently on the output.
    always_comb begin
        if (clear)     count = '0;
        else if (load) count = load_val;
        else           count = st;
    end

    udc_term #(.W(W)) i_term (
        .cnt      (count),
        .dir      (dir),
        .enable_n (enable_n),
        .term_n   (term_n)
    );
endmodule

// File: rtl/udc_chk.sv
// Module: property checker bound to every counter stage.
// Assumes: clear and load do not pulse between two edges of a checked step.
module udc_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         clear,
    input logic         load,
    input logic         count_up,
    input logic         enable_n,
    input logic [W-1:0] load_val,
    input logic [W-1:0] count,
    input logic         term_n
);
    // R1
    clear_zero_chk: assert property (@(posedge clk) clear |-> count == '0);
    // R2
    load_follow_chk: assert property (@(posedge clk) disable iff (clear)
        load |-> count == load_val);
    // R3
    step_up_chk: assert property (@(posedge clk) disable iff (clear)
        (!load && !enable_n && count_up) ##1 !load |-> count == W'($past(count) + 1'b1));
    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (clear)
        (!load && !enable_n && !count_up) ##1 !load |-> count == W'($past(count) - 1'b1));
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (clear)
        (!load && enable_n) ##1 !load |-> $stable(count));
    // R7
    term_enable_chk: assert property (@(posedge clk) disable iff (clear)
        !term_n |-> !enable_n);
    // R7
    term_value_chk: assert property (@(posedge clk) disable iff (clear)
        !term_n |-> (count_up ? (count == '1) : (count == '0)));
endmodule

bind updown_cascade_counter udc_chk #(.W(W)) i_chk (
    .clk      (clk),
    .clear    (clear),
    .load     (load),
    .count_up (count_up),
    .enable_n (enable_n),
    .load_val (load_val),
    .count    (count),
    .term_n   (term_n)
);

// File: tb/test_updown_cascade_counter.sv
module test_updown_cascade_counter;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       clear = 1'b1;
    logic       load = 1'b0;
    logic       count_up = 1'b1;
    logic       enable_n = 1'b1;
    logic [3:0] lv_lo = 4'h0;
    logic [3:0] lv_hi = 4'h0;
    logic [3:0] q_lo, q_hi;
    logic       t_lo, t_hi;
    int         n_chk = 0;
    int         n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    updown_cascade_counter #(.W(4)) i_updown_cascade_counter (
        .clk(clk), .clear(clear), .load(load), .count_up(count_up),
        .enable_n(enable_n), .load_val(lv_lo), .count(q_lo), .term_n(t_lo));

    updown_cascade_counter #(.W(4)) i_hi_stage (
        .clk(clk), .clear(clear), .load(load), .count_up(count_up),
        .enable_n(t_lo), .load_val(lv_hi), .count(q_hi), .term_n(t_hi));

    task automatic check(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_load(input logic [3:0] lo, input logic [3:0] hi);
        lv_lo = lo; lv_hi = hi; load = 1'b1;
        tick();
        load = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(q_lo, 0, "R1 reset state");
        clear = 1'b0;
        do_load(4'd9, 4'd0);
        #2 clear = 1'b1; load = 1'b1;
        #1 check(q_lo, 0, "R1 async clear over load");
        load = 1'b0;
        @(negedge clk); clear = 1'b0;
    endtask

    task automatic t_load();
        enable_n = 1'b0;
        #2 lv_lo = 4'd5; load = 1'b1;
        #1 check(q_lo, 5, "R2 follow at rise");
        lv_lo = 4'd11;
        #1 check(q_lo, 11, "R2 follow without edge");
        tick();
        load = 1'b0; enable_n = 1'b1;
        #1 check(q_lo, 11, "R8 held after load");
    endtask

    task automatic t_count();
        count_up = 1'b1; enable_n = 1'b0;
        do_load(4'd3, 4'd0);
        tick(); check(q_lo, 4, "R3 up step");
        tick(); check(q_lo, 5, "R3 up step again");
        count_up = 1'b0;
        tick(); check(q_lo, 4, "R4 down step");
        enable_n = 1'b1;
        tick(); tick(); check(q_lo, 4, "R5 hold");
        count_up = 1'b1;
        tick(); check(q_lo, 4, "R5 hold up");
    endtask

    task automatic t_wrap();
        enable_n = 1'b0; count_up = 1'b1;
        do_load(4'd15, 4'd0);
        tick(); check(q_lo, 0, "R6 up wrap");
        count_up = 1'b0;
        tick(); check(q_lo, 15, "R6 down wrap");
    endtask

    task automatic t_term();
        enable_n = 1'b1; count_up = 1'b1;
        do_load(4'd15, 4'd0);
        check(t_lo, 1, "R7 disabled high");
        enable_n = 1'b0;
        #1 check(t_lo, 0, "R7 up at 15");
        count_up = 1'b0;
        #1 check(t_lo, 1, "R7 dir change");
        enable_n = 1'b1;
        do_load(4'd0, 4'd0);
        enable_n = 1'b0;
        #1 check(t_lo, 0, "R7 down at 0");
        count_up = 1'b1;
        #1 check(t_lo, 1, "R7 up at 0");
        enable_n = 1'b1;
    endtask

    task automatic t_chain();
        int exp;
        enable_n = 1'b1; count_up = 1'b1;
        do_load(4'hD, 4'hF);
        exp = 8'hFD;
        enable_n = 1'b0;
        for (int i = 0; i < 20; i++) begin
            tick();
            exp = (exp + 1) % 256;
            check({q_hi, q_lo}, exp, "R9 chained up");
        end
        enable_n = 1'b1; count_up = 1'b0;
        do_load(4'h2, 4'h0);
        exp = 2;
        enable_n = 1'b0;
        for (int i = 0; i < 20; i++) begin
            tick();
            exp = (exp + 255) % 256;
            check({q_hi, q_lo}, exp, "R9 chained down");
        end
        enable_n = 1'b1;
        tick();
        check({q_hi, q_lo}, exp, "R5 chain hold");
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_load();
        t_count();
        t_wrap();
        t_term();
        t_chain();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule